// File: doc/BRIEF.md
# Dual-Path Lookahead Phase Synthesizer Core

This block is the digital front end of a direct digital synthesizer that feeds a two-path phase rotator. A phase register advances by a programmable step once per reference cycle. Two lookup paths turn phase into quadrature amplitude codes. The first path reads the phase as it stands. The second path reads the phase plus half the step, so it looks one half reference period ahead. The two paths are interleaved into a single stream at twice the reference rate, which places each lookahead sample at its true half-period instant. The odd image replicas of the reference rate then cancel, and the usable offset range reaches past the reference Nyquist limit.

Both paths share one clock that runs at twice the reference rate. An internal half-select toggles on every edge and defines which path is being sampled. A sign control negates the sine channel, so the same hardware produces either a positive or a negative frequency offset. Each 8-bit amplitude code leaves the block as a 4-bit binary low field plus a 15-line thermometer for the high field, ready to drive a segmented current-steering converter. The amplitude table holds one quarter wave and can be written at any time, so foreground pre-distortion values can replace the ideal sine.

Top module: `dds_lookahead_core`

## Requirements
- R1: While `rst` is high on a clock edge, `iCode` and `qCode` become 128 (midscale), `halfSel` becomes 0, and the phase, the latched step, the sign and the enable clear to zero.
- R2: After reset is released, `halfSel` is 1 in the first output cycle and then alternates on every clock. A value of 1 marks a path-1 sample and 0 marks a path-2 sample; each pair (1 then 0) forms one reference cycle.
- R3: At the end of every reference cycle the 20-bit phase advances by the effective step, modulo 2^20.
- R4: A path-1 sample reads table address phase[19:10]. A path-2 sample reads address (phase + floor(step/2))[19:10], computed modulo 2^20, using the same phase and step.
- R5: For a 10-bit address a, bit 8 mirrors the quarter index (index = 255 - a[7:0] when set, a[7:0] otherwise), and bit 9 selects negation. The code is 128 + m, or 128 - m when negated, where m is the 7-bit table entry. `qCode` (sine) uses address a; `iCode` (cosine) uses a + 256 modulo 1024.
- R6: When the latched sign is 1, the negation of `qCode` is inverted. `iCode` is unaffected.
- R7: `fcwIn`, `signIn` and `enIn` are sampled only on the clock edge that ends a reference cycle (the edge after a path-2 sample). Values present at any other edge have no effect on any output, and both paths of a reference cycle always use the same step and sign.
- R8: When the latched enable is 0, the effective step is 0. The phase holds, and both paths read the same address.
- R9: `iBin`/`qBin` equal code bits [3:0]. Bit k of `iTherm`/`qTherm` is 1 exactly when k < code[7:4].
- R10: A write with `tblWrEn` high stores `tblWrData` into quarter-table entry `tblWrAddr` at the clock edge. Reads from the following cycle onward see the new value, and writes are accepted during reset.
- R11: Each output code reflects the phase, step, sign and table contents present just before the clock edge that registers it. The output lags its phase by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the reference rate |
| rst | input | 1 | Synchronous reset, active high |
| fcwIn | input | 20 | Frequency step per reference cycle |
| signIn | input | 1 | 1 selects the negative frequency offset |
| enIn | input | 1 | 1 lets the phase advance |
| tblWrEn | input | 1 | Quarter-table write strobe |
| tblWrAddr | input | 8 | Quarter-table write index |
| tblWrData | input | 7 | Quarter-table magnitude value |
| halfSel | output | 1 | 1 for a path-1 sample, 0 for a path-2 sample |
| iCode | output | 8 | Cosine amplitude code, offset binary |
| qCode | output | 8 | Sine amplitude code, offset binary |
| iBin | output | 4 | Binary low field of iCode |
| iTherm | output | 15 | Thermometer of the iCode high field |
| qBin | output | 4 | Binary low field of qCode |
| qTherm | output | 15 | Thermometer of the qCode high field |

## Verification
The bench builds the core with its default parameters: a 20-bit phase, a 10-bit table address, 8-bit codes split 4/4, and a 256-entry quarter table. At that phase width, steps near 2^19 and at the top of the range reach all four quadrants within a few reference cycles. Odd steps make the floor of the half step visible in the path-2 address, and a step of all ones exercises the phase wrap. Because the table is only 256 entries deep, the bench can load the whole of it and then overwrite single entries mid-run to show that pre-distortion takes effect on the next read.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // strobes from the half-cycle control to the datapath
  typedef struct packed {
    logic pathOne;   // current clock samples path 1 (phase as is)
    logic refEdge;   // this edge closes a reference cycle
  } ddsStrobe_t;

endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output ddsStrobe_t strobe
);

  logic pathOne;

  always_ff @(posedge clk) begin
    if (rst) pathOne <= 1'b1;
    else     pathOne <= ~pathOne;
  end

  assign strobe.pathOne = pathOne;
  assign strobe.refEdge = ~pathOne;

endmodule

// File: rtl/dds_segment.sv
module dds_segment #(
  parameter int AMP_W = 8,
  parameter int LO_W  = 4,
  localparam int HI_W    = AMP_W - LO_W,
  localparam int THERM_W = (1 << HI_W) - 1
) (
  input  logic [AMP_W-1:0]   code,
  output logic [LO_W-1:0]    binPart,
  output logic [THERM_W-1:0] thermPart
);

  logic [HI_W-1:0] hiField;

  assign binPart = code[LO_W-1:0];
  assign hiField = code[AMP_W-1:LO_W];

  for (genvar k = 0; k < THERM_W; k++) begin : g_therm
    assign thermPart[k] = (int'(hiField) > k);
  end

endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int PHASE_W = 20,
  parameter int ADDR_W  = 10,
  parameter int AMP_W   = 8,
  localparam int QTR_W  = ADDR_W - 2,
  localparam int QTR_N  = 1 << QTR_W,
  localparam int MAG_W  = AMP_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  ddsStrobe_t         strobe,
  input  logic [PHASE_W-1:0] fcwIn,
  input  logic               signIn,
  input  logic               enIn,
  input  logic               tblWrEn,
  input  logic [QTR_W-1:0]   tblWrAddr,
  input  logic [MAG_W-1:0]   tblWrData,
  output logic               halfSel,
  output logic [AMP_W-1:0]   iCode,
  output logic [AMP_W-1:0]   qCode
);

  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  logic [PHASE_W-1:0] accQ, wordQ, stepW, phaseNow;
  logic               signQ, enQ;
  logic [ADDR_W-1:0]  baseAddr;
  logic [AMP_W-1:0]   codeNext [2];
  logic [MAG_W-1:0]   qtrTbl [QTR_N];

  // writable quarter-wave magnitude table, not reset
  always_ff @(posedge clk) begin
    if (tblWrEn) qtrTbl[tblWrAddr] <= tblWrData;
  end

  always_comb begin
    stepW    = enQ ? wordQ : '0;
    phaseNow = strobe.pathOne ? accQ : accQ + (stepW >> 1);
    baseAddr = phaseNow[PHASE_W-1 -: ADDR_W];
  end

  // channel 0: cosine (quarter turn ahead), channel 1: sine with sign
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] OFS = (ch == 0) ? ADDR_W'(QTR_N) : '0;
    logic [ADDR_W-1:0] addr;
    logic [QTR_W-1:0]  idx;
    logic [MAG_W-1:0]  mag;
    logic              negate;
    logic [AMP_W-1:0]  code;

    always_comb begin
      addr   = baseAddr + OFS;
      idx    = addr[ADDR_W-2] ? ~addr[QTR_W-1:0] : addr[QTR_W-1:0];
      mag    = qtrTbl[idx];
      negate = addr[ADDR_W-1] ^ ((ch == 1) ? signQ : 1'b0);
      code   = negate ? MID - AMP_W'(mag) : MID + AMP_W'(mag);
    end

    assign codeNext[ch] = code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ    <= '0;
      wordQ   <= '0;
      signQ   <= 1'b0;
      enQ     <= 1'b0;
      halfSel <= 1'b0;
      iCode   <= MID;
      qCode   <= MID;
    end else begin
      halfSel <= strobe.pathOne;
      iCode   <= codeNext[0];
      qCode   <= codeNext[1];
      if (strobe.refEdge) begin
        accQ  <= accQ + stepW;
        wordQ <= fcwIn;
        signQ <= signIn;
        enQ   <= enIn;
      end
    end
  end

  // R2
  halfSel_alt_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (halfSel != $past(halfSel)));

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe.pathOne)) |->
      ($stable(wordQ) && $stable(signQ) && $stable(enQ) && $stable(accQ)));

  // R8
  acc_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(enQ)) |-> $stable(accQ));

endmodule

// File: rtl/dds_lookahead_core.sv
module dds_lookahead_core
  import dds_pkg::*;
#(
  parameter int PHASE_W = 20,
  parameter int ADDR_W  = 10,
  parameter int AMP_W   = 8,
  parameter int LO_W    = 4,
  localparam int QTR_W   = ADDR_W - 2,
  localparam int MAG_W   = AMP_W - 1,
  localparam int HI_W    = AMP_W - LO_W,
  localparam int THERM_W = (1 << HI_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] fcwIn,
  input  logic               signIn,
  input  logic               enIn,
  input  logic               tblWrEn,
  input  logic [QTR_W-1:0]   tblWrAddr,
  input  logic [MAG_W-1:0]   tblWrData,
  output logic               halfSel,
  output logic [AMP_W-1:0]   iCode,
  output logic [AMP_W-1:0]   qCode,
  output logic [LO_W-1:0]    iBin,
  output logic [THERM_W-1:0] iTherm,
  output logic [LO_W-1:0]    qBin,
  output logic [THERM_W-1:0] qTherm
);

  ddsStrobe_t strobe;

  dds_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  dds_datapath #(
    .PHASE_W (PHASE_W),
    .ADDR_W  (ADDR_W),
    .AMP_W   (AMP_W)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .fcwIn     (fcwIn),
    .signIn    (signIn),
    .enIn      (enIn),
    .tblWrEn   (tblWrEn),
    .tblWrAddr (tblWrAddr),
    .tblWrData (tblWrData),
    .halfSel   (halfSel),
    .iCode     (iCode),
    .qCode     (qCode)
  );

  dds_segment #(.AMP_W(AMP_W), .LO_W(LO_W)) u_segI (
    .code      (iCode),
    .binPart   (iBin),
    .thermPart (iTherm)
  );

  dds_segment #(.AMP_W(AMP_W), .LO_W(LO_W)) u_segQ (
    .code      (qCode),
    .binPart   (qBin),
    .thermPart (qTherm)
  );

  // R9
  therm_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(iTherm) == int'(iCode[AMP_W-1 -: HI_W])) &&
    ($countones(qTherm) == int'(qCode[AMP_W-1 -: HI_W])));

  // R9
  therm_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (((iTherm + 1'b1) & iTherm) == '0) && (((qTherm + 1'b1) & qTherm) == '0));

endmodule

// File: tb/dds_lookahead_core_bench.sv
module dds_lookahead_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PMASK      = (1 << 20) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] fcwIn = '0;
  logic        signIn = 1'b0;
  logic        enIn = 1'b0;
  logic        tblWrEn = 1'b0;
  logic [7:0]  tblWrAddr = '0;
  logic [6:0]  tblWrData = '0;
  logic        halfSel;
  logic [7:0]  iCode, qCode;
  logic [3:0]  iBin, qBin;
  logic [14:0] iTherm, qTherm;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_lookahead_core u_dds_lookahead_core (
    .clk(clk), .rst(rst), .fcwIn(fcwIn), .signIn(signIn), .enIn(enIn),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .halfSel(halfSel), .iCode(iCode), .qCode(qCode),
    .iBin(iBin), .iTherm(iTherm), .qBin(qBin), .qTherm(qTherm)
  );

  int    nChecks = 0;
  int    nFail   = 0;
  bit    done    = 0;
  bit    live    = 0;
  string curReq  = "R1";

  // behavioural reference state
  int mTable [256];
  int mAcc, mWord, mSign, mEn;
  bit mSel;
  int expI, expQ, expHalf;

  function automatic int lookupCode(int a, int negFlip);
    int idx, neg, m;
    idx = ((a >> 8) & 1) ? 255 - (a & 255) : (a & 255);
    m   = mTable[idx];
    neg = ((a >> 9) & 1) ^ negFlip;
    return neg ? 128 - m : 128 + m;
  endfunction

  always @(posedge clk) begin
    int step, ph, a;
    live = 1;
    if (rst) begin
      mSel = 1; mAcc = 0; mWord = 0; mSign = 0; mEn = 0;
      expI = 128; expQ = 128; expHalf = 0;
    end else begin
      step = mEn ? mWord : 0;
      ph   = mSel ? mAcc : ((mAcc + step / 2) & PMASK);
      a    = ph >> 10;
      expI = lookupCode((a + 256) % 1024, 0);
      expQ = lookupCode(a, mSign);
      expHalf = mSel;
      if (!mSel) begin
        mAcc  = (mAcc + step) & PMASK;
        mWord = int'(fcwIn);
        mSign = int'(signIn);
        mEn   = int'(enIn);
      end
      mSel = !mSel;
    end
    if (tblWrEn) mTable[tblWrAddr] = int'(tblWrData);
  end

  task automatic chk(string req, string fld, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, fld, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk(rst ? "R1" : "R2", "halfSel", 32'(halfSel), 32'(expHalf));
      chk(rst ? "R1" : curReq, "iCode", 32'(iCode), 32'(expI));
      chk(rst ? "R1" : curReq, "qCode", 32'(qCode), 32'(expQ));
      chk("R9", "iBin", 32'(iBin), 32'(expI & 15));
      chk("R9", "qBin", 32'(qBin), 32'(expQ & 15));
      chk("R9", "iTherm", 32'(iTherm), 32'((1 << (expI >> 4)) - 1));
      chk("R9", "qTherm", 32'(qTherm), 32'((1 << (expQ >> 4)) - 1));
    end
  end

  task automatic setIn(int w, bit s, bit e);
    @(negedge clk);
    fcwIn = 20'(w); signIn = s; enIn = e;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeEntry(int idx, int val);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = 8'(idx); tblWrData = 7'(val);
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  initial begin
    // R10: load ideal quarter wave while reset is held
    curReq = "R1";
    for (int j = 0; j < 256; j++) begin
      @(negedge clk);
      tblWrEn = 1'b1; tblWrAddr = 8'(j);
      tblWrData = 7'(int'($floor(127.0 * $sin((j + 0.5) * 3.14159265358979 / 512.0) + 0.5)));
    end
    @(negedge clk);
    tblWrEn = 1'b0;
    run(4);
    // R1: explicit reset state
    chk("R1", "iCode_rst", 32'(iCode), 32'd128);
    chk("R1", "qCode_rst", 32'(qCode), 32'd128);
    chk("R1", "halfSel_rst", 32'(halfSel), 32'd0);
    rst = 1'b0;

    // R11 R2: idle core shows the zero-phase point on both halves
    curReq = "R11"; run(8);
    // R3 R4: moderate step
    curReq = "R3"; setIn(32'h01234, 0, 1); run(200);
    // R4: odd step makes floor of half step visible
    curReq = "R4"; setIn(32'h00C01, 0, 1); run(200);
    // R5: near and beyond half range, all quadrants
    curReq = "R5"; setIn(32'h7F000, 0, 1); run(200);
    setIn(32'hA3579, 0, 1); run(200);
    // R3: wrap with an all-ones step
    curReq = "R3"; setIn(32'hFFFFF, 0, 1); run(100);
    // R6: negative offset
    curReq = "R6"; setIn(32'h02468, 1, 1); run(200);
    // R7: glitch inputs on the non-boundary edge only
    curReq = "R7";
    for (int g = 0; g < 20; g++) begin
      while (mSel != 1) @(negedge clk);
      fcwIn = 20'h5A5A5; signIn = 1'b0; enIn = 1'b0;
      @(negedge clk);
      fcwIn = 20'h02468; signIn = 1'b1; enIn = 1'b1;
      run(3);
    end
    // R8: enable low freezes the phase, both paths equal
    curReq = "R8"; setIn(32'h33333, 0, 0); run(100);
    // R10: pre-distortion writes during operation
    curReq = "R10"; setIn(32'h00400, 0, 1);
    writeEntry(0, 40);
    writeEntry(255, 5);
    writeEntry(128, 99);
    run(400);
    curReq = "R11"; setIn(32'h40000, 0, 1); run(50);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule